// File: doc/BRIEF.md
# Serial Address Capture Controller

This block fetches a CPU address that two external 8-bit parallel-in/serial-out shift registers have latched. The two registers are chained. The block pulls an active-low load strobe to freeze the address in the external registers. It then toggles a shift clock and takes one bit from the serial line on every falling edge of that clock. The bits arrive in an order set by board routing, so the block rewires them back into address order.

The lowest address line does not travel in the serial frame. It comes in on its own parallel pin, which the block samples when it accepts the capture request. When every bit has arrived, the reassembled address and a 4-bit page nibble (the top four address bits) update together. A one-cycle valid pulse marks them. The whole transfer takes a fixed number of cycles, so it can be budgeted against the CPU's first wait state. A request that arrives while a capture is running is dropped.

Top module: `addr_capture`

## Requirements
- R1: One cycle after `start_i` is accepted in idle, `load_no` goes low. It stays low for exactly LOAD_CYC clock cycles, and only once per capture.
- R2: Per capture, `sclk_o` makes exactly FRAME_W (16) falling edges. Each high and low phase lasts SCLK_HALF cycles. The clock rests high when idle and while the load strobe is low.
- R3: The serial bit is sampled on each falling edge of `sclk_o`. Number the received slots k = 0..15, with slot 0 taken first. Slot 0 is a spare and is ignored. Slot k >= 1 carries address bit 1 + ((k-1)*7 mod 15).
- R4: Bit 0 of `addr_o` is the value of `lsb_i` in the cycle in which `start_i` was accepted. Later changes of `lsb_i` during the capture have no effect.
- R5: `valid_o` is high for exactly one cycle. It rises 1 + LOAD_CYC + 2*SCLK_HALF*FRAME_W rising clock edges after the edge that accepted `start_i`, counting that edge as the first.
- R6: `addr_o` and `page_o` change only in a cycle in which `valid_o` is high.
- R7: `page_o` equals `addr_o[15:12]`.
- R8: `start_i` asserted while a capture is in progress is ignored. It causes no extra load pulse, no extra valid pulse and no change to the captured address.
- R9: `busy_o` is high from the cycle after acceptance until the capture ends. It is low in the cycle in which `valid_o` is high.
- R10: During reset, `load_no` and `sclk_o` are high, and `valid_o`, `busy_o`, `addr_o` and `page_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture request, sampled only when idle |
| lsb_i | input | 1 | Lowest address line, parallel pin |
| sdata_i | input | 1 | Serial data from the external register chain |
| load_no | output | 1 | Parallel load strobe to the external registers, active low |
| sclk_o | output | 1 | Shift clock to the external registers |
| busy_o | output | 1 | Capture in progress |
| valid_o | output | 1 | One-cycle pulse marking a new address |
| addr_o | output | 16 | Reassembled address |
| page_o | output | 4 | Page nibble, top four address bits |

## Verification
The bench builds the block with its defaults: 16-bit address, two 8-bit registers, a two-cycle load strobe, two-cycle shift clock phases and a permutation stride of 7. With these values the full 67-cycle latency can be checked cycle-exactly. Every one of the 15 permuted positions can be driven to distinct values by patterns of all-zeros, all-ones, alternating bits and random words. A stray request can be placed in the middle of the shift phase, with a flipped lowest address bit, so that both the ignored-request and the lowest-bit capture rules are exercised.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT
  } acq_state_e;

  // address bit fed by kept serial position j (j = 0 first kept bit)
  function automatic int perm_bit(input int j, input int stride, input int span);
    return 1 + ((j * stride) % span);
  endfunction
endpackage

// File: rtl/acq_seq.sv
module acq_seq #(
  parameter int FRAME_W   = 16,
  parameter int LOAD_CYC  = 2,
  parameter int SCLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_no,
  output logic sclk_o,
  output logic sample_o,
  output logic done_o,
  output logic accept_o,
  output logic busy_o
);
  import acq_pkg::*;

  localparam int LD_CW  = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
  localparam int PH_CW  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  acq_state_e         state_q;
  logic [LD_CW-1:0]   ld_cnt_q;
  logic [PH_CW-1:0]   ph_cnt_q;
  logic [BIT_CW-1:0]  bit_cnt_q;
  logic               load_nq;
  logic               sclk_q;
  logic               phase_end;

  assign phase_end = (state_q == ST_SHIFT) && (ph_cnt_q == PH_CW'(SCLK_HALF - 1));
  assign sample_o  = phase_end && sclk_q;
  assign done_o    = phase_end && !sclk_q && (bit_cnt_q == BIT_CW'(FRAME_W - 1));
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign load_no   = load_nq;
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ld_cnt_q  <= '0;
      ph_cnt_q  <= '0;
      bit_cnt_q <= '0;
      load_nq   <= 1'b1;
      sclk_q    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_LOAD;
            ld_cnt_q <= '0;
            load_nq  <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (ld_cnt_q == LD_CW'(LOAD_CYC - 1)) begin
            state_q   <= ST_SHIFT;
            load_nq   <= 1'b1;
            ph_cnt_q  <= '0;
            bit_cnt_q <= '0;
          end else begin
            ld_cnt_q <= ld_cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (phase_end) begin
            ph_cnt_q <= '0;
            sclk_q   <= ~sclk_q;
            if (!sclk_q) begin
              if (bit_cnt_q == BIT_CW'(FRAME_W - 1)) state_q <= ST_IDLE;
              else bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  load_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_no) |-> $past(start_i));

  // R2
  sclk_idle_during_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_no |-> sclk_o);

  // R8
  no_reload_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> !$fell(load_no));
endmodule

// File: rtl/acq_rx.sv
module acq_rx #(
  parameter int CAP_W = 15
) (
  input  logic             clk_i,
  input  logic             sample_i,
  input  logic             sdata_i,
  output logic [CAP_W-1:0] frame_o
);
  logic [CAP_W-1:0] rx_q;

  // no preset: leading spare slots fall off the top
  always_ff @(posedge clk_i) begin
    if (sample_i) rx_q <= {rx_q[CAP_W-2:0], sdata_i};
  end

  assign frame_o = rx_q;
endmodule

// File: rtl/acq_unscramble.sv
module acq_unscramble #(
  parameter int ADDR_W = 16,
  parameter int STRIDE = 7
) (
  input  logic [ADDR_W-2:0] frame_i,
  input  logic              lsb_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CAP_W = ADDR_W - 1;

  assign addr_o[0] = lsb_i;

  for (genvar j = 0; j < CAP_W; j++) begin : g_map
    assign addr_o[acq_pkg::perm_bit(j, STRIDE, CAP_W)] = frame_i[CAP_W-1-j];
  end
endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int ADDR_W    = 16,
  parameter int REG_W     = 8,
  parameter int NUM_REGS  = 2,
  parameter int LOAD_CYC  = 2,
  parameter int SCLK_HALF = 2,
  parameter int STRIDE    = 7,
  parameter int PAGE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              lsb_i,
  input  logic              sdata_i,
  output logic              load_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int FRAME_W = REG_W * NUM_REGS;
  localparam int CAP_W   = ADDR_W - 1;

  logic              sample, done, accept;
  logic              lsb_q;
  logic [CAP_W-1:0]  frame;
  logic [ADDR_W-1:0] addr_n;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  acq_seq #(
    .FRAME_W  (FRAME_W),
    .LOAD_CYC (LOAD_CYC),
    .SCLK_HALF(SCLK_HALF)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_no (load_no),
    .sclk_o  (sclk_o),
    .sample_o(sample),
    .done_o  (done),
    .accept_o(accept),
    .busy_o  (busy_o)
  );

  acq_rx #(.CAP_W(CAP_W)) u_rx (
    .clk_i   (clk_i),
    .sample_i(sample),
    .sdata_i (sdata_i),
    .frame_o (frame)
  );

  acq_unscramble #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_unscr (
    .frame_i(frame),
    .lsb_i  (lsb_q),
    .addr_o (addr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q   <= 1'b0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept) lsb_q <= lsb_i;
      if (done) addr_q <= addr_n;
      valid_q <= done;
    end
  end

  assign addr_o  = addr_q;
  assign page_o  = addr_q[ADDR_W-1 -: PAGE_W];
  assign valid_o = valid_q;

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(addr_o));

  // R9
  idle_at_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
endmodule

// File: tb/tb_addr_capture.sv
`timescale 1ns/1ps
module tb_addr_capture;
  localparam int ADDR_W = 16;
  localparam int FRAME_W = 16;
  localparam int LOAD_CYC = 2;
  localparam int SCLK_HALF = 2;
  localparam int STRIDE = 7;
  localparam int LAT = 1 + LOAD_CYC + 2 * SCLK_HALF * FRAME_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic lsb_i = 1'b0;
  logic sdata_i;
  logic load_no, sclk_o, busy_o, valid_o;
  logic [15:0] addr_o;
  logic [3:0] page_o;

  int checks = 0;
  int errors = 0;
  int falls = 0;
  int ld_cyc = 0;
  int ld_pulses = 0;
  bit done_flag = 0;
  bit mon_en = 0;
  logic [15:0] prev_addr = '0;
  logic [15:0] ext_frame = '0;
  logic [15:0] ext_sh = '0;

  always #2.5 clk = ~clk;

  addr_capture dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .lsb_i(lsb_i),
    .sdata_i(sdata_i), .load_no(load_no), .sclk_o(sclk_o), .busy_o(busy_o),
    .valid_o(valid_o), .addr_o(addr_o), .page_o(page_o)
  );

  // external register chain model: parallel load while strobe low, shift on rising clock
  always @(negedge load_no or posedge sclk_o) begin
    if (!load_no) ext_sh = ext_frame;
    else ext_sh = {ext_sh[14:0], 1'b0};
  end
  assign sdata_i = ext_sh[15];

  always @(negedge sclk_o) if (mon_en) falls++;
  always @(negedge load_no) if (mon_en) ld_pulses++;
  always @(negedge clk) if (mon_en && !load_no) ld_cyc++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (!valid_o && addr_o !== prev_addr) check(1'b0, "R6 addr changed without valid", addr_o, prev_addr);
      prev_addr = addr_o;
    end
  end

  function automatic logic [15:0] build_frame(input logic [15:0] a, input bit spare);
    logic [15:0] f;
    f[15] = spare;
    for (int j = 0; j < ADDR_W - 1; j++) f[14-j] = a[1 + ((j * STRIDE) % (ADDR_W - 1))];
    return f;
  endfunction

  task automatic capture(input logic [15:0] a, input bit lsbv, input bit spare, input bit poke);
    logic [15:0] exp;
    int n;
    exp = {a[15:1], lsbv};
    ext_frame = build_frame(a, spare);
    lsb_i = lsbv;
    @(negedge clk);
    falls = 0; ld_cyc = 0; ld_pulses = 0;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    n = 1;
    check(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    while (!valid_o && n < 400) begin
      if (poke && n == 20) begin start_i = 1'b1; lsb_i = ~lsbv; end
      if (poke && n == 23) start_i = 1'b0;
      @(posedge clk); #1;
      n++;
    end
    lsb_i = lsbv;
    check(n == LAT, "R5 latency", n, LAT);
    check(addr_o == exp, "R3/R4 address", addr_o, exp);
    check(page_o == exp[15:12], "R7 page nibble", page_o, exp[15:12]);
    check(falls == FRAME_W, "R2 falling edges", falls, FRAME_W);
    check(ld_cyc == LOAD_CYC, "R1 load width", ld_cyc, LOAD_CYC);
    check(ld_pulses == 1, "R8 single load pulse", ld_pulses, 1);
    check(busy_o == 1'b0, "R9 idle at valid", busy_o, 0);
    @(posedge clk); #1;
    check(valid_o == 1'b0, "R5 valid one cycle", valid_o, 0);
    check(busy_o == 1'b0, "R8 no restart after ignored request", busy_o, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R10
    check(load_no == 1'b1, "R10 load idle", load_no, 1);
    check(sclk_o == 1'b1, "R10 sclk idle", sclk_o, 1);
    check(valid_o == 1'b0, "R10 valid", valid_o, 0);
    check(busy_o == 1'b0, "R10 busy", busy_o, 0);
    check(addr_o == 16'h0 && page_o == 4'h0, "R10 addr", addr_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); mon_en = 1;
    capture(16'h0000, 1'b0, 1'b1, 1'b0);
    capture(16'hFFFF, 1'b1, 1'b0, 1'b0);
    capture(16'hAAAA, 1'b1, 1'b1, 1'b0);
    capture(16'h5555, 1'b0, 1'b0, 1'b0);
    capture(16'h8002, 1'b0, 1'b1, 1'b1);  // R8 stray request, R4 lsb flip
    for (int i = 0; i < 15; i++) capture(16'h1 << (i + 1), 1'b0, 1'b0, 1'b0);  // R3 each position
    for (int i = 0; i < 24; i++) begin
      r = 16'($urandom);
      capture(r, r[0] ^ r[7], 1'($urandom), (i % 5) == 0);
    end
    finish_run();
  end
endmodule